// File: doc/BRIEF.md
# Splitter-Chain Stochastic Number Generator

This block turns an N-bit binary fraction into a serial bitstream whose density of ones equals the fraction, value/2^N. It does not compare a random word against the value. Each enabled clock cycle is treated as one event. The event enters a chain of N random two-way steering stages. At every stage a random bit either captures the event on that stage's terminal output or passes it on to the next stage. Stage k therefore captures the event with probability 2^-k. If no stage captures the event, it is lost.

A bank of set-only hold registers stores the value. Each terminal output is gated by the hold bit of matching binary weight, and the gated terminals are ORed into a single stream bit. At most one terminal fires per event, so the probability of a one is exactly the stored value. The hold bits are not disturbed by producing stream bits, so an L-bit stream costs L enabled cycles and no reloads. To set a new value, clear the bank and then load it. The random bits come from an internal LFSR that advances only on enabled cycles.

Top module: `splitter_sng`

## Requirements
- R1: After reset, stream_o and valid_o are 0 and the stored value is 0.
- R2: valid_o is 1 in exactly the cycle after each cycle with enable_i high, and 0 otherwise. stream_o is 0 whenever valid_o is 0.
- R3: In any cycle at most one steering stage captures the event. Stage k (k = 1..N) captures it with probability 2^-k. With only value bit N-k set, the measured density is 2^-k.
- R4: value_i bit N-1 (weight 1/2) gates stage 1 and bit 0 (weight 2^-N) gates stage N. Over 4096 enabled cycles the count of ones is within 160 of value*4096/2^N for every value 0..2^N-1.
- R5: With a stored value of 0, stream_o is never 1.
- R6: Producing stream bits does not alter the stored value. A second run of 4096 cycles without a reload gives the same density.
- R7: clear_i zeroes the stored value and takes priority over load_i in the same cycle.
- R8: load_i with clear_i low ORs value_i into the stored value.
- R9: While enable_i is low no random bits are consumed. The sequence of stream bits over enabled cycles after reset is the same whether or not idle cycles are inserted between them.
- R10: With all value bits set, the density is (2^N-1)/2^N. Only the event that passes every stage yields a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero all hold bits |
| load_i | input | 1 | OR value_i into the hold bits |
| value_i | input | N | Binary fraction, MSB has weight 1/2 |
| enable_i | input | 1 | Produce one stream bit this cycle |
| stream_o | output | 1 | Registered stream bit |
| valid_o | output | 1 | stream_o holds a bit from the previous enabled cycle |

## Verification
The bench loads every value and counts the ones in long runs. A reversed bit-to-stage mapping moves 1/16 onto the half-weight stage, and the counts for 1, 2, 4 and 8 expose it. A chain that does not exclude the captures of other stages lets several terminals fire in the same cycle and inflates the density of mixed values such as 15 and 9. The bench also runs clear and load together and a load over an uncleared value. A load that overwrites the hold bits, or a clear that loses to load, shows up as a nonzero count where silence or 9/16 is expected. Finally, the bench replays the stream after reset with idle gaps inserted. An LFSR that steps while idle produces a different bit sequence.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int unsigned SSG_VALUE_W = 4;
  localparam int unsigned SSG_LFSR_W  = 16;
  localparam logic [15:0] SSG_TAPS    = 16'hD008;  // x^16+x^15+x^13+x^4+1
  localparam logic [15:0] SSG_SEED    = 16'hACE1;
endpackage

// File: rtl/ssg_lfsr.sv
module ssg_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 'd1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_o <= SEED;
    else if (adv_i) state_o <= {state_o[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0);  // R3
  AST_LFSR_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_o));  // R9
endmodule

// File: rtl/ssg_chain.sv
module ssg_chain #(
  parameter int unsigned N = 4
) (
  input  logic         event_i,
  input  logic [N-1:0] rnd_i,   // 1 = capture here, 0 = pass on
  output logic [N-1:0] term_o
);
  logic [N:0] pass;
  assign pass[0] = event_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign term_o[k]  = pass[k] &  rnd_i[k];
    assign pass[k+1]  = pass[k] & ~rnd_i[k];
  end
endmodule

// File: rtl/ssg_hold_bank.sv
module ssg_hold_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [N-1:0] value_i,
  output logic [N-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_o <= '0;
    else if (clear_i) hold_o <= '0;
    else if (load_i)  hold_o <= hold_o | value_i;  // set-only
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> hold_o == '0);  // R7
  AST_LOAD_MERGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> hold_o == ($past(hold_o) | $past(value_i)));  // R8
  AST_HOLD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i) |=> $stable(hold_o));  // R6
endmodule

// File: rtl/splitter_sng.sv
module splitter_sng
  import ssg_pkg::*;
#(
  parameter int unsigned N      = SSG_VALUE_W,
  parameter int unsigned LFSR_W = SSG_LFSR_W,
  parameter logic [LFSR_W-1:0] TAPS = SSG_TAPS,
  parameter logic [LFSR_W-1:0] SEED = SSG_SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [N-1:0] value_i,
  input  logic         enable_i,
  output logic         stream_o,
  output logic         valid_o
);
  localparam int unsigned STRIDE = (LFSR_W >= 3 * N) ? 3 : 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [N-1:0]      rnd, term, hold, gate;
  logic              hit;

  ssg_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni, .adv_i(enable_i), .state_o(lfsr_q)
  );

  ssg_hold_bank #(.N(N)) u_hold (
    .clk_i, .rst_ni, .clear_i, .load_i, .value_i, .hold_o(hold)
  );

  for (genvar k = 0; k < N; k++) begin : g_tap
    assign rnd[k]  = lfsr_q[(k * STRIDE) % LFSR_W];
    assign gate[k] = term[k] & hold[N-1-k];  // stage k+1 has weight 2^-(k+1)
  end

  ssg_chain #(.N(N)) u_chain (
    .event_i(enable_i), .rnd_i(rnd), .term_o(term)
  );

  assign hit = |gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stream_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      stream_o <= enable_i & hit;
      valid_o  <= enable_i;
    end
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(term));  // R3
  AST_VALID_TRACKS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> valid_o);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !stream_o);  // R2
  AST_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && hold == '0) |=> !stream_o);  // R5
endmodule

// File: tb/splitter_sng_test.sv
module splitter_sng_test;
  localparam int N = 4;
  localparam int RUN = 4096;
  localparam int TOL = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ld = 1'b0, en = 1'b0;
  logic [N-1:0] val = '0;
  logic stream, valid;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] rec_a, rec_b;

  always #2ns clk = ~clk;  // 250 MHz

  splitter_sng #(.N(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .load_i(ld),
    .value_i(val), .enable_i(en), .stream_o(stream), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic c, input logic l, input logic [N-1:0] v);
    en = e; clr = c; ld = l; val = v;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0; clr = 1'b0; ld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_value(input logic [N-1:0] v);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic count_run(input int n, output int ones, output int vals);
    ones = 0; vals = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, '0);
      vals += int'(valid);
      ones += int'(stream);
    end
  endtask

  function automatic bit near(input int act, input int exp);
    return (act >= exp - TOL) && (act <= exp + TOL);
  endfunction

  task automatic t_reset();
    int ones, vals;
    do_reset();
    check(stream == 1'b0, "R1 stream after reset", int'(stream), 0);
    check(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    count_run(256, ones, vals);
    check(ones == 0, "R1 stored value zero after reset", ones, 0);
  endtask

  task automatic t_valid();
    step(1'b0, 1'b0, 1'b0, '0);
    check(valid == 1'b0, "R2 valid low after idle", int'(valid), 0);
    set_value(4'hF);
    step(1'b1, 1'b0, 1'b0, '0);
    check(valid == 1'b1, "R2 valid after enabled cycle", int'(valid), 1);
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b0, 1'b0, '0);
      check(valid == 1'b0 && stream == 1'b0, "R2 idle cycle quiet",
            int'({valid, stream}), 0);
    end
  endtask

  task automatic t_density_all();
    int ones, vals, exp;
    for (int v = 0; v < (1 << N); v++) begin
      set_value(N'(v));
      count_run(RUN, ones, vals);
      exp = v * RUN / (1 << N);
      check(vals == RUN, "R2 valid count", vals, RUN);
      if (v == 0)
        check(ones == 0, "R5 zero value emits no ones", ones, 0);
      else if (v == 8 || v == 4 || v == 2 || v == 1)
        check(near(ones, exp), "R3 single-stage density", ones, exp);
      else if (v == (1 << N) - 1)
        check(near(ones, exp), "R10 full value density", ones, exp);
      else
        check(near(ones, exp), "R4 weighted density", ones, exp);
    end
  endtask

  task automatic t_persist();
    int ones, vals, exp;
    set_value(4'h5);
    exp = 5 * RUN / 16;
    count_run(RUN, ones, vals);
    check(near(ones, exp), "R6 first run density", ones, exp);
    count_run(RUN, ones, vals);
    check(near(ones, exp), "R6 second run without reload", ones, exp);
  endtask

  task automatic t_clear_priority();
    int ones, vals;
    set_value(4'hF);
    step(1'b0, 1'b1, 1'b1, 4'hF);
    count_run(1024, ones, vals);
    check(ones == 0, "R7 clear beats load", ones, 0);
    set_value(4'hF);
    step(1'b0, 1'b1, 1'b0, '0);
    count_run(1024, ones, vals);
    check(ones == 0, "R7 clear empties hold bits", ones, 0);
  endtask

  task automatic t_load_or();
    int ones, vals, exp;
    set_value(4'h8);
    step(1'b0, 1'b0, 1'b1, 4'h1);
    exp = 9 * RUN / 16;
    count_run(RUN, ones, vals);
    check(near(ones, exp), "R8 load ORs into held value", ones, exp);
  endtask

  task automatic t_idle_no_consume();
    int k;
    do_reset();
    set_value(4'h8);
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b0, 1'b0, '0);
      rec_a[i] = stream;
    end
    do_reset();
    set_value(4'h8);
    k = 0;
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < (i % 3); j++) step(1'b0, 1'b0, 1'b0, '0);
      step(1'b1, 1'b0, 1'b0, '0);
      rec_b[i] = stream;
    end
    for (int i = 0; i < 64; i++) if (rec_a[i] != rec_b[i]) k++;
    check(k == 0, "R9 idle gaps leave sequence unchanged", k, 0);
    check(rec_a != '0 && rec_a != '1, "R9 sequence not constant", int'(rec_a[31:0]), -1);
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_valid();
    t_density_all();
    t_persist();
    t_clear_priority();
    t_load_or();
    t_idle_no_consume();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule